// File: doc/BRIEF.md
# Center-Aligned PWM Timer Channel

The block generates one center-aligned pulse-width-modulated output from a 16-bit up/down counter. A free-running prescaler turns the core clock into counting ticks at a power-of-two fraction of its rate. On each tick the counter climbs from zero to the period limit and then falls back to zero; one full climb and descent is one PWM period of `2 × limit` ticks. The output is active while the counter is below the compare level, so the active pulse sits symmetrically around count zero.

Software loads the period limit and the compare level one byte at a time through write strobes. Bytes go to holding registers. A value takes effect only after both of its bytes have arrived, and only at the moment the counter returns to zero, so a period in progress is never cut short or stretched. Duty-cycle corners are exact: a compare level at or above the limit holds the pin active, a level with its top bit set holds it inactive, and a level of limit minus one still gives a nearly full pulse. A polarity input chooses whether active means high or low.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the counter is at zero, both working values are zero and the pin is at its inactive level (low when `pol_high`=1, high when `pol_high`=0).
- R2: With limit M>0 the counter runs 0,1,…,M,M−1,…,1 and repeats, so one period lasts 2·M ticks and contains exactly one active pulse.
- R3: `presc_sel` code k makes one tick every 2^k clocks: code 0 ticks every clock, code 1 every 2 clocks, code 3 every 8 clocks.
- R4: For a compare level C with 0≤C<M, the pin is active for exactly 2·C ticks of each 2·M-tick period, as one contiguous pulse centred on count zero; C=0 gives no active time.
- R5: A compare level C with bit 15 clear and C≥M (M>0), including C=M, holds the pin active for the whole period.
- R6: A compare level of M−1 gives 2·M−2 active ticks per period and never falls to zero duty.
- R7: Any compare level with bit 15 set (0x8000 to 0xFFFF) holds the pin inactive.
- R8: A byte write (`*_hi_we` loads bits 15:8, `*_lo_we` loads bits 7:0 from `wdata`) changes only the holding register; a 16-bit value moves to the working register only after both of its bytes have been written since the last transfer, and only on the tick at which the counter arrives at zero. A single byte write has no effect on the output.
- R9: `pol_high`=1 makes the active level high; `pol_high`=0 makes it low.
- R10: With limit M=0 the counter stays at zero and the pin is active exactly when 0<C<0x8000; C=0 keeps it inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_sel | input | 3 | Prescaler code k, tick every 2^k clocks |
| pol_high | input | 1 | 1: active level high, 0: active level low |
| wdata | input | 8 | Byte written by any strobe |
| lim_hi_we | input | 1 | Write `wdata` to bits 15:8 of the pending limit |
| lim_lo_we | input | 1 | Write `wdata` to bits 7:0 of the pending limit |
| cmp_hi_we | input | 1 | Write `wdata` to bits 15:8 of the pending compare level |
| cmp_lo_we | input | 1 | Write `wdata` to bits 7:0 of the pending compare level |
| pwm_out | output | 1 | PWM output pin |

## Verification
The pin follows the counter state one clock later because the active decision is registered, while a polarity change shows at once. A newly written value waits for the counter to arrive at zero, which can take up to one full old period of `2·M·2^k` clocks, so every scenario waits 400 clocks, more than two of the longest periods used, before it looks at the pin. Duty and pulse count are then measured over a window of exactly one period in clocks, sampled on the falling edge; since the waveform is periodic, the totals do not depend on where the window starts.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cpwm_dir_t;
endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("cpwm_prescale: SEL_W out of range");
   end

   logic [DIV_W-1:0] pcnt_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      mask = ~({DIV_W{1'b1}} << sel);
      tick = &(pcnt_q | ~mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
   end

   // R3: code zero must tick on every clock
   a_r3_div_one : assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> tick);
endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hi_we,
   input  logic           lo_we,
   input  logic [W/2-1:0] wbyte,
   input  logic           commit,
   output logic [W-1:0]   work
);
   localparam int HW = W / 2;

   if (W < 4 || (W % 2) != 0) begin : g_bad_w
      $error("cpwm_shadow: W must be even and at least 4");
   end

   logic [W-1:0] hold_q;
   logic         hi_seen_q, lo_seen_q;
   logic         load;

   assign load = commit & hi_seen_q & lo_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         work      <= '0;
         hi_seen_q <= 1'b0;
         lo_seen_q <= 1'b0;
      end else begin
         if (load)  work <= hold_q;
         if (hi_we) hold_q[W-1:HW] <= wbyte;
         if (lo_we) hold_q[HW-1:0] <= wbyte;
         hi_seen_q <= hi_we | (hi_seen_q & ~load);
         lo_seen_q <= lo_we | (lo_seen_q & ~load);
      end
   end

   // R8: working value moves only on a commit request
   a_r8_commit_gate : assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(work));
endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown
   import cpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output cpwm_dir_t    dir
);
   logic [W-1:0] cnt_inc, cnt_dec;

   assign cnt_inc = cnt + 1'b1;
   assign cnt_dec = cnt - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         dir <= DIR_UP;
      end else if (tick) begin
         if (limit == '0) begin
            cnt <= '0;
            dir <= DIR_UP;
         end else if (cnt == '0) begin
            cnt <= {{(W-1){1'b0}}, 1'b1};
            dir <= (limit == {{(W-1){1'b0}}, 1'b1}) ? DIR_DOWN : DIR_UP;
         end else if (dir == DIR_UP) begin
            cnt <= cnt_inc;
            if (cnt_inc >= limit) dir <= DIR_DOWN;
         end else begin
            cnt <= cnt_dec;
            if (cnt_dec == '0) dir <= DIR_UP;
         end
      end
   end

   // R2: the sweep never passes the limit
   a_r2_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);
   // R2: counting advances only on prescaler ticks
   a_r2_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
   import cpwm_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SEL_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  presc_sel,
   input  logic              pol_high,
   input  logic [DATA_W/2-1:0] wdata,
   input  logic              lim_hi_we,
   input  logic              lim_lo_we,
   input  logic              cmp_hi_we,
   input  logic              cmp_lo_we,
   output logic              pwm_out
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data_w
      $error("cpwm_timer: DATA_W must be even and at least 4");
   end

   logic              tick, commit;
   logic [DATA_W-1:0] lim_w, cmp_w, cnt;
   cpwm_dir_t         dir;
   logic              full_on, in_pulse, active_nxt, active;

   cpwm_prescale #(.SEL_W(SEL_W)) i_presc (
      .clk(clk), .rst_n(rst_n), .sel(presc_sel), .tick(tick));

   // transfer on the tick that brings the counter to zero (or keeps it there)
   assign commit = tick & ((lim_w == '0) |
                   ((dir == DIR_DOWN) & (cnt == {{(DATA_W-1){1'b0}}, 1'b1})));

   cpwm_shadow #(.W(DATA_W)) i_lim (
      .clk(clk), .rst_n(rst_n), .hi_we(lim_hi_we), .lo_we(lim_lo_we),
      .wbyte(wdata), .commit(commit), .work(lim_w));

   cpwm_shadow #(.W(DATA_W)) i_cmp (
      .clk(clk), .rst_n(rst_n), .hi_we(cmp_hi_we), .lo_we(cmp_lo_we),
      .wbyte(wdata), .commit(commit), .work(cmp_w));

   cpwm_updown #(.W(DATA_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .limit(lim_w),
      .cnt(cnt), .dir(dir));

   always_comb begin
      full_on    = !cmp_w[MSB] && (lim_w != '0) && (cmp_w >= lim_w);
      in_pulse   = !cmp_w[MSB] &&
                   ((dir == DIR_UP) ? (cnt < cmp_w) : (cnt <= cmp_w));
      active_nxt = full_on | in_pulse;
   end

   if (OUT_REG) begin : g_out_reg
      logic active_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) active_q <= 1'b0;
         else        active_q <= active_nxt;
      end
      assign active = active_q;

      // R7: negative compare level forces the inactive state
      a_r7_neg_off : assert property (@(posedge clk) disable iff (!rst_n)
         cmp_w[MSB] |=> !active);
      // R5: compare at or above a nonzero limit forces the active state
      a_r5_full_on : assert property (@(posedge clk) disable iff (!rst_n)
         (!cmp_w[MSB] && lim_w != '0 && cmp_w >= lim_w) |=> active);
   end else begin : g_out_comb
      assign active = active_nxt;
   end

   assign pwm_out = pol_high ? active : ~active;

   // R8: a new limit appears only together with a counter at zero
   a_r8_zero_swap : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lim_w) |-> (cnt == '0));
endmodule

// File: tb/test_cpwm_timer.sv
`timescale 1ns/1ps
module test_cpwm_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] presc_sel = 3'd0;
   logic       pol_high = 1'b1;
   logic [7:0] wdata = 8'h00;
   logic       lim_hi_we = 1'b0, lim_lo_we = 1'b0;
   logic       cmp_hi_we = 1'b0, cmp_lo_we = 1'b0;
   logic       pwm_out;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   cpwm_timer i_cpwm_timer (
      .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .pol_high(pol_high),
      .wdata(wdata), .lim_hi_we(lim_hi_we), .lim_lo_we(lim_lo_we),
      .cmp_hi_we(cmp_hi_we), .cmp_lo_we(cmp_lo_we), .pwm_out(pwm_out));

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_byte(input int sel, input logic [7:0] b);
      @(negedge clk);
      wdata = b;
      lim_hi_we = (sel == 0); lim_lo_we = (sel == 1);
      cmp_hi_we = (sel == 2); cmp_lo_we = (sel == 3);
      @(negedge clk);
      lim_hi_we = 1'b0; lim_lo_we = 1'b0; cmp_hi_we = 1'b0; cmp_lo_we = 1'b0;
   endtask

   task automatic set_lim(input logic [15:0] v);
      wr_byte(0, v[15:8]); wr_byte(1, v[7:0]);
   endtask

   task automatic set_cmp(input logic [15:0] v);
      wr_byte(2, v[15:8]); wr_byte(3, v[7:0]);
   endtask

   // counts high samples and rising edges over n clocks
   task automatic measure(input int n, output int highs, output int rises);
      logic prev;
      @(negedge clk);
      prev = pwm_out;
      highs = 0; rises = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
         if (pwm_out && !prev) rises++;
         prev = pwm_out;
      end
   endtask

   task automatic t_reset;
      int h, r;
      measure(20, h, r);
      check("R1 inactive low after reset", h, 0);
      pol_high = 1'b0;
      @(negedge clk);
      measure(20, h, r);
      check("R1 inactive high with low polarity", h, 20);
      pol_high = 1'b1;
   endtask

   task automatic t_zero_limit;
      int h, r;
      set_cmp(16'd5); idle(400);
      measure(20, h, r);
      check("R10 zero limit positive compare held active", h, 20);
      set_cmp(16'd0); idle(400);
      measure(20, h, r);
      check("R10 zero limit zero compare held inactive", h, 0);
   endtask

   task automatic t_duty;
      int h, r;
      set_lim(16'd10);
      set_cmp(16'd4); idle(400);
      measure(20, h, r);
      check("R4 duty C=4 M=10", h, 8);
      check("R2 one pulse per period", r, 1);
      set_cmp(16'd1); idle(400);
      measure(20, h, r);
      check("R4 duty C=1 M=10", h, 2);
      measure(40, h, r);
      check("R2 two pulses in two periods", r, 2);
      set_cmp(16'd0); idle(400);
      measure(20, h, r);
      check("R4 duty C=0", h, 0);
   endtask

   task automatic t_full;
      int h, r;
      set_cmp(16'd10); idle(400);
      measure(20, h, r);
      check("R5 C equal M full on", h, 20);
      set_cmp(16'd12); idle(400);
      measure(20, h, r);
      check("R5 C above M full on", h, 20);
      set_cmp(16'd9); idle(400);
      measure(20, h, r);
      check("R6 C=M-1 nearly full", h, 18);
   endtask

   task automatic t_negative;
      int h, r;
      set_cmp(16'h8000); idle(400);
      measure(20, h, r);
      check("R7 compare 0x8000 off", h, 0);
      set_cmp(16'hFFFF); idle(400);
      measure(20, h, r);
      check("R7 compare 0xFFFF off", h, 0);
   endtask

   task automatic t_prescale;
      int h, r;
      set_cmp(16'd4);
      presc_sel = 3'd2; idle(400);
      measure(80, h, r);
      check("R3 code 2 duty over 80 clocks", h, 32);
      check("R3 code 2 one pulse per 80 clocks", r, 1);
      presc_sel = 3'd3; idle(400);
      measure(160, h, r);
      check("R3 code 3 duty over 160 clocks", h, 64);
      check("R3 code 3 one pulse per 160 clocks", r, 1);
      presc_sel = 3'd0; idle(400);
   endtask

   task automatic t_polarity;
      int h, r;
      pol_high = 1'b0;
      @(negedge clk);
      measure(20, h, r);
      check("R9 low-active high samples", h, 12);
      pol_high = 1'b1;
      @(negedge clk);
      measure(20, h, r);
      check("R9 high-active high samples", h, 8);
   endtask

   task automatic t_half_write;
      int h, r;
      wr_byte(2, 8'h80); idle(400);
      measure(20, h, r);
      check("R8 lone high byte ignored", h, 8);
      wr_byte(3, 8'h03); idle(400);
      measure(20, h, r);
      check("R8 pair complete 0x8003 applied", h, 0);
      set_cmp(16'd4); idle(400);
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_zero_limit();
      t_duty();
      t_full();
      t_negative();
      t_prescale();
      t_polarity();
      t_half_write();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule